// File: doc/BRIEF.md
# Device Control Register with Write-Triggered Actions

This block holds one 16-bit device control word and turns writes to it into side effects. A host write strobe with 16 bits of data updates the stored fields. In the cycle after the strobe, the block can issue one-cycle action pulses: calibration start, ramp start and phase sync. A write with the soft-reset bit set returns every field to its default value. That bit clears itself and never reads back as 1.

Calibration start and ramp start fire on every write whose data has the matching bit set, even when the stored bit is already 1. The sync pulse fires only when the phase-sync bit goes from 0 to 1. The fixed fields always read back their constant values. The calibration-enable bit cannot be cleared: a write that tries to clear it sets a sticky flag instead. A mute output combines the stored mute field with the calibration-busy input from the calibration engine. A ramp-done input clears the stored ramp-enable bit when the ramp engine finishes.

Top module: `devctl_reg`

## Requirements
- R1: After `rst_ni` is deasserted and before any write, `rd_data_o` equals 16'h221C. In that value the fixed bits [13:12]=2'b10, [4]=1 and [3]=1 are set, as are mute [9]=1 and mux select [2]=1. All pulses and `illegal_wr_o` are 0.
- R2: A write without soft reset stores data bits [15] ramp, [14] sync, [11] address hold, [9] mute, [8:7] high adjust, [6:5] low adjust, [2] mux select and [0] power-down. The new value shows on `rd_data_o` and on the field outputs in the cycle after the strobe.
- R3: Bits [13:12] always read 2'b10, bit [10] reads 0, bit [4] reads 1 and bit [1] reads 0, whatever data is written.
- R4: A write with data bit [3]=1, bit [1]=0 and bit [0]=0 raises `cal_start_o` for exactly one cycle, in the cycle after the strobe. This happens even when the stored bit [3] is already 1.
- R5: A write with data bit [15]=1, bit [1]=0 and bit [0]=0 raises `ramp_start_o` for exactly one cycle, in the cycle after the strobe. This holds even when the write is only meant to retrigger calibration.
- R6: A write with data bit [14]=1 and bit [1]=0 raises `sync_pulse_o` for one cycle after the strobe, but only when the stored bit [14] was 0. Rewriting 1 over a stored 1 gives no pulse.
- R7: A write with data bit [1]=1 loads the defaults of R1 and emits no pulse, whatever the other data bits are.
- R8: `mute_o` is 1 exactly when the stored mute bit [9] is 1 and `cal_busy_i` is 1.
- R9: A write with data bit [3]=0 and bit [1]=0 leaves bit [3] at 1 and sets `illegal_wr_o` one cycle after the strobe. The flag stays set until `rst_ni`.
- R10: A written power-down bit [0]=1 suppresses `cal_start_o` and `ramp_start_o` for that write. It has no effect on the sync pulse.
- R11: When `ramp_done_i` is 1 in a cycle with no write, the stored ramp bit [15] reads 0 in the following cycle. A write in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| cal_busy_i | input | 1 | Calibration engine busy |
| ramp_done_i | input | 1 | Ramp engine finished |
| rd_data_o | output | 16 | Read-back of the control word |
| ramp_en_o | output | 1 | Stored ramp enable |
| sync_en_o | output | 1 | Stored phase-sync enable |
| addr_hold_o | output | 1 | Stored address hold |
| mute_en_o | output | 1 | Stored mute-during-calibration enable |
| cal_hi_adj_o | output | 2 | High comparison-rate calibration adjust |
| cal_lo_adj_o | output | 2 | Low comparison-rate calibration adjust |
| cal_en_o | output | 1 | Calibration enable (always 1) |
| mux_sel_o | output | 1 | Monitor pin select |
| pwr_dn_o | output | 1 | Power-down level |
| cal_start_o | output | 1 | Calibration start pulse |
| ramp_start_o | output | 1 | Ramp start pulse |
| sync_pulse_o | output | 1 | Phase sync pulse |
| mute_o | output | 1 | Output mute |
| illegal_wr_o | output | 1 | Sticky flag: attempt to clear calibration enable |

## Verification
Directed writes repeat the calibration bit and the sync bit back to back. The repeated calibration write must pulse again while the repeated sync write must stay silent, which separates change detection from level detection. Other directed writes combine power-down with the calibration and ramp bits, which exposes any suppression that reaches the sync pulse too. They also pair soft reset with every action bit set, which shows whether reset takes priority. Random writes with rare soft resets, random busy levels and random ramp-done cycles check readback, pulses and mute against a bench model on every cycle. This shows whether reserved bits leak through and whether ramp-done is wrongly honoured during a write.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
  localparam int unsigned DW = 16;

  localparam int unsigned B_RAMP  = 15;
  localparam int unsigned B_SYNC  = 14;
  localparam int unsigned B_HOLD  = 11;
  localparam int unsigned B_MUTE  = 9;
  localparam int unsigned B_HADJ  = 7;
  localparam int unsigned B_LADJ  = 5;
  localparam int unsigned B_CAL   = 3;
  localparam int unsigned B_MUX   = 2;
  localparam int unsigned B_SRST  = 1;
  localparam int unsigned B_PD    = 0;
  localparam int unsigned ADJ_W   = 2;

  localparam logic [DW-1:0] WR_MASK  = 16'hCBE5;
  localparam logic [DW-1:0] FIX_VAL  = 16'h2018;
  localparam logic [DW-1:0] DEF_VAL  = 16'h221C;

  typedef struct packed {
    logic cal;
    logic ramp;
    logic sync;
  } act_t;
endpackage

// File: rtl/devctl_fields.sv
module devctl_fields
  import devctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ramp_done_i,
  output logic [DW-1:0] word_o,
  output logic          illegal_o
);
  logic [DW-1:0] var_q, var_d;
  logic          ill_q, ill_d;
  logic          srst;

  assign srst = wr_en_i & wr_data_i[B_SRST];

  always_comb begin
    var_d = var_q;
    ill_d = ill_q;
    if (wr_en_i) begin
      if (srst) begin
        var_d = DEF_VAL & WR_MASK;
      end else begin
        var_d = wr_data_i & WR_MASK;
        if (!wr_data_i[B_CAL]) ill_d = 1'b1;
      end
    end else if (ramp_done_i) begin
      var_d[B_RAMP] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      var_q <= DEF_VAL & WR_MASK;
      ill_q <= 1'b0;
    end else begin
      var_q <= var_d;
      ill_q <= ill_d;
    end
  end

  assign word_o    = var_q | FIX_VAL;
  assign illegal_o = ill_q;

  // R3
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_o[13:12] == 2'b10) && !word_o[10] && word_o[4] && word_o[3] && !word_o[1]);
  // R9
  illegal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);
  // R7
  srst_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (word_o == DEF_VAL));
endmodule

// File: rtl/devctl_actions.sv
module devctl_actions
  import devctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          sync_cur_i,
  output act_t          act_o
);
  act_t act_q, act_d;
  logic ok, run;

  assign ok  = wr_en_i & ~wr_data_i[B_SRST];
  assign run = ok & ~wr_data_i[B_PD];

  always_comb begin
    act_d.cal  = run & wr_data_i[B_CAL];
    act_d.ramp = run & wr_data_i[B_RAMP];
    act_d.sync = ok & wr_data_i[B_SYNC] & ~sync_cur_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  assign act_o = act_q;

  // R4
  cal_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o.cal |-> $past(wr_en_i));
  // R5
  ramp_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o.ramp |-> $past(wr_en_i));
  // R6
  sync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o.sync |-> ($past(wr_en_i) && !$past(sync_cur_i)));
  // R7
  srst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[B_SRST]) |=> (act_o == '0));
  // R10
  pd_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[B_PD]) |=> (!act_o.cal && !act_o.ramp));
endmodule

// File: rtl/devctl_reg.sv
module devctl_reg
  import devctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [15:0]   wr_data_i,
  input  logic          cal_busy_i,
  input  logic          ramp_done_i,
  output logic [15:0]   rd_data_o,
  output logic          ramp_en_o,
  output logic          sync_en_o,
  output logic          addr_hold_o,
  output logic          mute_en_o,
  output logic [1:0]    cal_hi_adj_o,
  output logic [1:0]    cal_lo_adj_o,
  output logic          cal_en_o,
  output logic          mux_sel_o,
  output logic          pwr_dn_o,
  output logic          cal_start_o,
  output logic          ramp_start_o,
  output logic          sync_pulse_o,
  output logic          mute_o,
  output logic          illegal_wr_o
);
  logic [DW-1:0] word;
  act_t          act;

  devctl_fields u_fields (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .ramp_done_i,
    .word_o(word), .illegal_o(illegal_wr_o)
  );

  devctl_actions u_actions (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .sync_cur_i(word[B_SYNC]), .act_o(act)
  );

  assign rd_data_o    = word;
  assign ramp_en_o    = word[B_RAMP];
  assign sync_en_o    = word[B_SYNC];
  assign addr_hold_o  = word[B_HOLD];
  assign mute_en_o    = word[B_MUTE];
  assign cal_hi_adj_o = word[B_HADJ +: ADJ_W];
  assign cal_lo_adj_o = word[B_LADJ +: ADJ_W];
  assign cal_en_o     = word[B_CAL];
  assign mux_sel_o    = word[B_MUX];
  assign pwr_dn_o     = word[B_PD];
  assign cal_start_o  = act.cal;
  assign ramp_start_o = act.ramp;
  assign sync_pulse_o = act.sync;
  assign mute_o       = mute_en_o & cal_busy_i;

  // R4
  cal_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_start_o && !$past(wr_en_i, 2)) |=> !cal_start_o || $past(wr_en_i));
  // R8
  mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> (rd_data_o[B_MUTE] && cal_busy_i));
endmodule

// File: tb/devctl_reg_tb_top.sv
module devctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        cal_busy = 1'b0;
  logic        ramp_done = 1'b0;
  logic [15:0] rd_data;
  logic        ramp_en, sync_en, addr_hold, mute_en, cal_en, mux_sel, pwr_dn;
  logic [1:0]  hi_adj, lo_adj;
  logic        cal_start, ramp_start, sync_pulse, mute, illegal;

  int checks = 0;
  int failures = 0;
  logic [15:0] m_word = 16'h221C;
  logic        m_ill = 1'b0;
  logic [2:0]  m_act = '0;

  always #2.5 clk = ~clk;

  devctl_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cal_busy_i(cal_busy), .ramp_done_i(ramp_done), .rd_data_o(rd_data),
    .ramp_en_o(ramp_en), .sync_en_o(sync_en), .addr_hold_o(addr_hold),
    .mute_en_o(mute_en), .cal_hi_adj_o(hi_adj), .cal_lo_adj_o(lo_adj),
    .cal_en_o(cal_en), .mux_sel_o(mux_sel), .pwr_dn_o(pwr_dn),
    .cal_start_o(cal_start), .ramp_start_o(ramp_start),
    .sync_pulse_o(sync_pulse), .mute_o(mute), .illegal_wr_o(illegal)
  );

  function automatic logic [15:0] next_word(logic [15:0] w, logic [15:0] d);
    if (d[1]) return 16'h221C;
    return (d & 16'hCBE5) | 16'h2018;
  endfunction

  function automatic logic [2:0] next_act(logic [15:0] w, logic [15:0] d);
    logic [2:0] a;
    a[2] = !d[1] && !d[0] && d[3];
    a[1] = !d[1] && !d[0] && d[15];
    a[0] = !d[1] && d[14] && !w[14];
    return a;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, rd_data, m_word);
    chk(req, {ramp_en, sync_en, addr_hold, mute_en, hi_adj, lo_adj, cal_en, mux_sel, pwr_dn},
        {m_word[15], m_word[14], m_word[11], m_word[9], m_word[8:7], m_word[6:5],
         m_word[3], m_word[2], m_word[0]});
    chk(req, {cal_start, ramp_start, sync_pulse}, m_act);
    chk({req, "/R8"}, mute, m_word[9] & cal_busy);
    chk({req, "/R9"}, illegal, m_ill);
  endtask

  // one cycle: drive at negedge, update model at posedge, sample at next negedge
  task automatic step(logic we, logic [15:0] d, logic rd, logic busy, string req);
    @(negedge clk);
    wr_en = we; wr_data = d; ramp_done = rd; cal_busy = busy;
    @(posedge clk);
    if (we) begin
      m_act = next_act(m_word, d);
      if (!d[1] && !d[3]) m_ill = 1'b1;
      m_word = next_word(m_word, d);
    end else begin
      m_act = '0;
      if (rd) m_word[15] = 1'b0;
    end
    @(negedge clk);
    wr_en = 1'b0; ramp_done = 1'b0;
    check_all(req);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1");

    step(1, 16'h0BE5 | 16'h0008, 0, 0, "R2");
    step(1, 16'hFFFF & ~16'h0002 & ~16'h0001, 0, 0, "R3");
    step(1, 16'h0008, 0, 0, "R4");
    step(1, 16'h0008, 0, 0, "R4 repeat");
    step(1, 16'h8008, 0, 0, "R5");
    step(1, 16'h8008, 0, 0, "R5 retrigger");
    step(0, 16'h0, 0, 0, "R4 one-cycle");
    step(1, 16'h4008, 0, 0, "R6 rise");
    step(1, 16'h4008, 0, 0, "R6 hold");
    step(1, 16'h0008, 0, 0, "R6 clear");
    step(1, 16'hC009, 0, 0, "R10");
    step(1, 16'hC00A, 0, 0, "R7");
    step(1, 16'h0208, 0, 1, "R8 busy");
    step(0, 16'h0, 0, 0, "R8 idle");
    step(1, 16'h0000, 0, 0, "R9");
    step(1, 16'h0008, 0, 0, "R9 sticky");
    step(1, 16'h8000 | 16'h0008 | 16'h0001, 0, 0, "R11 set");
    step(1, 16'h8009, 1, 0, "R11 write wins");
    step(0, 16'h0, 1, 0, "R11 clear");

    for (int i = 0; i < 2000; i++) begin
      d = 16'($urandom);
      if ($urandom % 8 != 0) d[1] = 1'b0;
      if ($urandom % 4 != 0) d[3] = 1'b1;
      step(($urandom % 3) != 0, d, $urandom % 2 == 1, $urandom % 2 == 1, "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule